// File: doc/BRIEF.md
# Text-Mode Character Pixel Generator

This block turns a stream of screen pixel coordinates into pixel colors for a text display built from 8x8 character cells. Each pixel passes through three lookups in turn. The cell coordinates (x and y with their three low bits dropped) address a character memory whose entry holds a glyph number and a color attribute. The glyph number, joined with the row inside the cell, addresses a glyph memory that returns one 8-pixel row of the glyph shape. The column inside the cell picks one bit of that row. That bit does not carry a color. It chooses between the foreground and the background half of the attribute, and the chosen 4-bit color number indexes a small color table that holds the final 12-bit color.

A display timing source presents one coordinate pair per clock with a valid strobe, and receives colors with a matching valid flag three cycles later. Each of the three tables has its own write port. Software or a loader fills the tables while no pixels are being requested. Scrolling, sprites and the generation of timing are left to other blocks.

Top module: `chargen_pipe`

## Requirements
- R1: After reset, and again after any later reset, pix_valid is 0 and pix_color is 0. Pixels that were in flight when reset arrived produce no output.
- R2: A pixel presented with px_valid high in cycle n gives exactly one result with pix_valid high in cycle n+3. A new pixel may be presented every cycle, and no result appears without a request.
- R3: The character memory entry used for pixel (x, y) is at address (y >> 3) * 32 + (x >> 3). The entry's bits [15:8] hold the glyph number and bits [7:0] hold the attribute.
- R4: The glyph row used is at glyph memory address glyph * 8 + (y & 7). The leftmost pixel of a cell (x & 7 = 0) takes row bit 7, and x & 7 = 7 takes row bit 0.
- R5: If the selected glyph bit is 1, the output color is the color table entry numbered by attribute bits [7:4] (foreground). If the bit is 0, the entry numbered by attribute bits [3:0] (background) is used.
- R6: In any cycle where pix_valid is 0, pix_color keeps the value it had in the previous cycle.
- R7: A write to any of the three tables changes the colors of every pixel requested after the write. The write ports are used only while px_valid is low.
- R8: Pixels presented back to back that fall in different cells, cell rows or rows inside a cell each get the color for their own coordinates. The in-cell coordinate bits stay aligned with the table data at every stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| px_valid | input | 1 | Pixel request strobe |
| px_x | input | 8 | Pixel column |
| px_y | input | 7 | Pixel row |
| cm_we | input | 1 | Character memory write enable |
| cm_addr | input | 9 | Character memory write address (cell index) |
| cm_data | input | 16 | Character entry: glyph number [15:8], attribute [7:0] |
| gm_we | input | 1 | Glyph memory write enable |
| gm_addr | input | 11 | Glyph memory write address (glyph * 8 + row) |
| gm_data | input | 8 | Glyph row, bit 7 is the leftmost pixel |
| ct_we | input | 1 | Color table write enable |
| ct_addr | input | 4 | Color table write address |
| ct_data | input | 12 | Color value |
| pix_valid | output | 1 | Output color valid |
| pix_color | output | 12 | Output pixel color |

## Verification
The hardest case to reach is a wrong pairing between an in-cell coordinate bit and the table data it belongs to, because a misaligned delay only shows up when neighbouring pixels differ in cell, glyph row and bit at once. The stimulus therefore streams whole scan lines back to back over tables filled with patterns that are different everywhere, and compares every output against a model of the three lookups. Directed cells with one-bit glyph rows (only the leftmost bit or only the rightmost bit set) and distinct foreground and background colors fix the bit order and the foreground/background choice. A second pass rewrites entries between scans to show that the writes take effect.

// File: rtl/chargen_pkg.sv
package chargen_pkg;

   // fixed cell geometry and entry layout
   localparam int CELL_LOG2 = 3;
   localparam int ROW_W     = 2 ** CELL_LOG2;
   localparam int GLYPH_W   = 8;
   localparam int NIB_W     = 4;
   localparam int ATTR_W    = 2 * NIB_W;
   localparam int CT_AW     = NIB_W;

   typedef struct packed {
      logic [GLYPH_W-1:0] glyph;
      logic [ATTR_W-1:0]  attr;
   } char_entry_t;

   localparam int ENTRY_W = $bits(char_entry_t);

endpackage

// File: rtl/cg_sync_ram.sv
module cg_sync_ram #(
   parameter int AW        = 4,
   parameter int DW        = 8,
   parameter bit OUT_RESET = 1'b0
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic          rd_en,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data
);

   localparam int DEPTH = 2 ** AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         mem[wr_addr] <= wr_data;
      end
   end

   generate
      if (OUT_RESET) begin : g_rst_out
         always_ff @(posedge clk) begin
            if (rst) begin
               rd_data <= '0;
            end else if (rd_en) begin
               rd_data <= mem[rd_addr];
            end
         end
      end else begin : g_plain_out
         logic unused_rst;
         assign unused_rst = rst;
         always_ff @(posedge clk) begin
            if (rd_en) begin
               rd_data <= mem[rd_addr];
            end
         end
      end
   endgenerate

endmodule

// File: rtl/cg_cell_fetch.sv
module cg_cell_fetch
   import chargen_pkg::*;
#(
   parameter int COLS_LOG2 = 5,
   parameter int ROWS_LOG2 = 4
) (
   input  logic                           clk,
   input  logic                           rst,
   input  logic                           in_valid,
   input  logic [COLS_LOG2+CELL_LOG2-1:0] in_x,
   input  logic [ROWS_LOG2+CELL_LOG2-1:0] in_y,
   input  logic                           wr_en,
   input  logic [COLS_LOG2+ROWS_LOG2-1:0] wr_addr,
   input  char_entry_t                    wr_data,
   output logic                           out_valid,
   output char_entry_t                    out_entry,
   output logic [CELL_LOG2-1:0]           out_fx,
   output logic [CELL_LOG2-1:0]           out_fy
);

   localparam int XW = COLS_LOG2 + CELL_LOG2;
   localparam int YW = ROWS_LOG2 + CELL_LOG2;
   localparam int AW = COLS_LOG2 + ROWS_LOG2;

   logic [AW-1:0]      cell_addr;
   logic [ENTRY_W-1:0] entry_raw;

   // row-major cell index: cell row above cell column
   assign cell_addr = {in_y[YW-1:CELL_LOG2], in_x[XW-1:CELL_LOG2]};

   cg_sync_ram #(
      .AW        (AW),
      .DW        (ENTRY_W),
      .OUT_RESET (1'b0)
   ) char_ram_i (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_en   (in_valid),
      .rd_addr (cell_addr),
      .rd_data (entry_raw)
   );

   assign out_entry = char_entry_t'(entry_raw);

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
      end else begin
         out_valid <= in_valid;
      end
   end

   always_ff @(posedge clk) begin
      if (in_valid) begin
         out_fx <= in_x[CELL_LOG2-1:0];
         out_fy <= in_y[CELL_LOG2-1:0];
      end
   end

endmodule

// File: rtl/cg_glyph_fetch.sv
module cg_glyph_fetch
   import chargen_pkg::*;
(
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         in_valid,
   input  char_entry_t                  in_entry,
   input  logic [CELL_LOG2-1:0]         in_fx,
   input  logic [CELL_LOG2-1:0]         in_fy,
   input  logic                         wr_en,
   input  logic [GLYPH_W+CELL_LOG2-1:0] wr_addr,
   input  logic [ROW_W-1:0]             wr_data,
   output logic                         out_valid,
   output logic [ROW_W-1:0]             out_row,
   output logic [ATTR_W-1:0]            out_attr,
   output logic [CELL_LOG2-1:0]         out_fx
);

   localparam int AW = GLYPH_W + CELL_LOG2;

   logic [AW-1:0] row_addr;

   assign row_addr = {in_entry.glyph, in_fy};

   cg_sync_ram #(
      .AW        (AW),
      .DW        (ROW_W),
      .OUT_RESET (1'b0)
   ) glyph_ram_i (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_en   (in_valid),
      .rd_addr (row_addr),
      .rd_data (out_row)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
      end else begin
         out_valid <= in_valid;
      end
   end

   always_ff @(posedge clk) begin
      if (in_valid) begin
         out_attr <= in_entry.attr;
         out_fx   <= in_fx;
      end
   end

endmodule

// File: rtl/cg_color_stage.sv
module cg_color_stage
   import chargen_pkg::*;
#(
   parameter int COLOR_W   = 12,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 in_valid,
   input  logic [ROW_W-1:0]     in_row,
   input  logic [ATTR_W-1:0]    in_attr,
   input  logic [CELL_LOG2-1:0] in_fx,
   input  logic                 wr_en,
   input  logic [CT_AW-1:0]     wr_addr,
   input  logic [COLOR_W-1:0]   wr_data,
   output logic                 out_valid,
   output logic [COLOR_W-1:0]   out_color
);

   logic [CELL_LOG2-1:0] bit_idx;
   logic                 fg_sel;
   logic [CT_AW-1:0]     color_idx;

   generate
      if (MSB_FIRST) begin : g_msb_first
         // leftmost pixel sits in the top bit of the row
         assign bit_idx = ~in_fx;
      end else begin : g_lsb_first
         assign bit_idx = in_fx;
      end
   endgenerate

   assign fg_sel    = in_row[bit_idx];
   assign color_idx = fg_sel ? in_attr[ATTR_W-1:NIB_W] : in_attr[NIB_W-1:0];

   cg_sync_ram #(
      .AW        (CT_AW),
      .DW        (COLOR_W),
      .OUT_RESET (1'b1)
   ) color_ram_i (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_en   (in_valid),
      .rd_addr (color_idx),
      .rd_data (out_color)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
      end else begin
         out_valid <= in_valid;
      end
   end

endmodule

// File: rtl/chargen_pipe.sv
module chargen_pipe
   import chargen_pkg::*;
#(
   parameter int COLS_LOG2 = 5,
   parameter int ROWS_LOG2 = 4,
   parameter int COLOR_W   = 12,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic                           clk,
   input  logic                           rst,
   input  logic                           px_valid,
   input  logic [COLS_LOG2+CELL_LOG2-1:0] px_x,
   input  logic [ROWS_LOG2+CELL_LOG2-1:0] px_y,
   input  logic                           cm_we,
   input  logic [COLS_LOG2+ROWS_LOG2-1:0] cm_addr,
   input  logic [ENTRY_W-1:0]             cm_data,
   input  logic                           gm_we,
   input  logic [GLYPH_W+CELL_LOG2-1:0]   gm_addr,
   input  logic [ROW_W-1:0]               gm_data,
   input  logic                           ct_we,
   input  logic [CT_AW-1:0]               ct_addr,
   input  logic [COLOR_W-1:0]             ct_data,
   output logic                           pix_valid,
   output logic [COLOR_W-1:0]             pix_color
);

   localparam int XW = COLS_LOG2 + CELL_LOG2;
   localparam int YW = ROWS_LOG2 + CELL_LOG2;

   generate
      if (COLS_LOG2 < 1 || ROWS_LOG2 < 1) begin : g_bad_grid
         $error("chargen_pipe: the cell grid needs at least two columns and two rows");
      end
      if (COLS_LOG2 + ROWS_LOG2 > 12) begin : g_big_grid
         $error("chargen_pipe: character memory depth exceeds 4096 cells");
      end
      if (COLOR_W < 1 || COLOR_W > 32) begin : g_bad_color
         $error("chargen_pipe: COLOR_W must lie in 1..32");
      end
      if (XW < CELL_LOG2 + 1 || YW < CELL_LOG2 + 1) begin : g_bad_coord
         $error("chargen_pipe: coordinate width too small for the cell size");
      end
   endgenerate

   // stage 1 outputs
   logic                 s1_valid;
   char_entry_t          s1_entry;
   logic [CELL_LOG2-1:0] s1_fx;
   logic [CELL_LOG2-1:0] s1_fy;

   // stage 2 outputs
   logic                 s2_valid;
   logic [ROW_W-1:0]     s2_row;
   logic [ATTR_W-1:0]    s2_attr;
   logic [CELL_LOG2-1:0] s2_fx;

   cg_cell_fetch #(
      .COLS_LOG2 (COLS_LOG2),
      .ROWS_LOG2 (ROWS_LOG2)
   ) cell_i (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (px_valid),
      .in_x      (px_x),
      .in_y      (px_y),
      .wr_en     (cm_we),
      .wr_addr   (cm_addr),
      .wr_data   (char_entry_t'(cm_data)),
      .out_valid (s1_valid),
      .out_entry (s1_entry),
      .out_fx    (s1_fx),
      .out_fy    (s1_fy)
   );

   cg_glyph_fetch glyph_i (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (s1_valid),
      .in_entry  (s1_entry),
      .in_fx     (s1_fx),
      .in_fy     (s1_fy),
      .wr_en     (gm_we),
      .wr_addr   (gm_addr),
      .wr_data   (gm_data),
      .out_valid (s2_valid),
      .out_row   (s2_row),
      .out_attr  (s2_attr),
      .out_fx    (s2_fx)
   );

   cg_color_stage #(
      .COLOR_W   (COLOR_W),
      .MSB_FIRST (MSB_FIRST)
   ) color_i (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (s2_valid),
      .in_row    (s2_row),
      .in_attr   (s2_attr),
      .in_fx     (s2_fx),
      .wr_en     (ct_we),
      .wr_addr   (ct_addr),
      .wr_data   (ct_data),
      .out_valid (pix_valid),
      .out_color (pix_color)
   );

endmodule

// File: rtl/chargen_pipe_chk.sv
module chargen_pipe_chk #(
   parameter int COLOR_W = 12
) (
   input logic               clk,
   input logic               rst,
   input logic               px_valid,
   input logic               cm_we,
   input logic               gm_we,
   input logic               ct_we,
   input logic               pix_valid,
   input logic [COLOR_W-1:0] pix_color
);

   // cycles since reset, saturating at the pipeline depth
   logic [1:0] age;
   logic       rst_d;

   always_ff @(posedge clk) begin
      rst_d <= rst;
      if (rst) begin
         age <= 2'd0;
      end else if (age != 2'd3) begin
         age <= age + 2'd1;
      end
   end

   // R1: outputs cleared by reset
   always @(negedge clk) begin
      if (rst_d) begin
         a_reset_clear_r1: assert (!pix_valid && pix_color == '0)
            else $error("outputs not cleared by reset");
      end
   end

   // R2: one result three cycles after each request
   p_latency_r2: assert property (@(posedge clk) disable iff (rst)
      (age == 2'd3) |-> (pix_valid == $past(px_valid, 3)));

   // R6: color holds while no result is delivered
   p_hold_color_r6: assert property (@(posedge clk) disable iff (rst)
      ((age != 2'd0) && !pix_valid) |-> $stable(pix_color));

   // R7: table writes only while no pixel is requested
   p_write_idle_r7: assert property (@(posedge clk) disable iff (rst)
      px_valid |-> !(cm_we || gm_we || ct_we));

   // R5: a delivered color is never unknown
   p_color_known_r5: assert property (@(posedge clk) disable iff (rst)
      pix_valid |-> !$isunknown(pix_color));

endmodule

bind chargen_pipe chargen_pipe_chk #(
   .COLOR_W (COLOR_W)
) chk_i (
   .clk       (clk),
   .rst       (rst),
   .px_valid  (px_valid),
   .cm_we     (cm_we),
   .gm_we     (gm_we),
   .ct_we     (ct_we),
   .pix_valid (pix_valid),
   .pix_color (pix_color)
);

// File: tb/chargen_pipe_tb_top.sv
module chargen_pipe_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int XW = 8;
   localparam int YW = 7;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        px_valid = 1'b0;
   logic [7:0]  px_x = '0;
   logic [6:0]  px_y = '0;
   logic        cm_we = 1'b0;
   logic [8:0]  cm_addr = '0;
   logic [15:0] cm_data = '0;
   logic        gm_we = 1'b0;
   logic [10:0] gm_addr = '0;
   logic [7:0]  gm_data = '0;
   logic        ct_we = 1'b0;
   logic [3:0]  ct_addr = '0;
   logic [11:0] ct_data = '0;
   logic        pix_valid;
   logic [11:0] pix_color;

   int    checks = 0;
   int    errors = 0;
   string cur_req = "R1";
   bit    mon_on = 1'b0;

   // shadow tables
   logic [15:0] m_cm [512];
   logic [7:0]  m_gm [2048];
   logic [11:0] m_ct [16];

   logic [11:0] q_exp [$];
   logic [2:0]  ev;
   logic [11:0] last_col;

   always #(CLK_PERIOD/2) clk = ~clk;

   chargen_pipe dut_i (
      .clk       (clk),
      .rst       (rst),
      .px_valid  (px_valid),
      .px_x      (px_x),
      .px_y      (px_y),
      .cm_we     (cm_we),
      .cm_addr   (cm_addr),
      .cm_data   (cm_data),
      .gm_we     (gm_we),
      .gm_addr   (gm_addr),
      .gm_data   (gm_data),
      .ct_we     (ct_we),
      .ct_addr   (ct_addr),
      .ct_data   (ct_data),
      .pix_valid (pix_valid),
      .pix_color (pix_color)
   );

   function automatic logic [11:0] model(input logic [7:0] x, input logic [6:0] y);
      logic [15:0] e;
      logic [7:0]  row;
      logic        sel;
      logic [3:0]  idx;
      e   = m_cm[{y[6:3], x[7:3]}];
      row = m_gm[{e[15:8], y[2:0]}];
      sel = row[3'd7 - x[2:0]];
      idx = sel ? e[7:4] : e[3:0];
      return m_ct[idx];
   endfunction

   // request side of the model
   always @(posedge clk) begin
      if (rst) begin
         ev <= 3'b000;
         q_exp.delete();
      end else begin
         ev <= {ev[1:0], px_valid};
         if (px_valid) q_exp.push_back(model(px_x, px_y));
      end
      if (cm_we) m_cm[cm_addr] = cm_data;
      if (gm_we) m_gm[gm_addr] = gm_data;
      if (ct_we) m_ct[ct_addr] = ct_data;
   end

   // result side: every cycle checked against the model
   always @(negedge clk) begin
      if (rst) begin
         last_col = '0;
      end else if (mon_on) begin
         checks++;
         if (pix_valid !== ev[2]) begin
            errors++;
            $display("FAIL R2: pix_valid=%b expected %b", pix_valid, ev[2]);
         end else if (pix_valid) begin
            if (q_exp.size() == 0) begin
               errors++;
               $display("FAIL R2: pix_color=%h expected none pending", pix_color);
            end else begin
               logic [11:0] e;
               e = q_exp.pop_front();
               if (pix_color !== e) begin
                  errors++;
                  $display("FAIL %s: pix_color=%h expected %h", cur_req, pix_color, e);
               end
            end
            last_col = pix_color;
         end else if (pix_color !== last_col) begin
            errors++;
            $display("FAIL R6: pix_color=%h expected %h", pix_color, last_col);
         end
      end
   end

   task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr_cm(input int a, input logic [15:0] d);
      @(negedge clk); cm_we = 1'b1; cm_addr = a[8:0]; cm_data = d;
      @(negedge clk); cm_we = 1'b0;
   endtask

   task automatic wr_gm(input int a, input logic [7:0] d);
      @(negedge clk); gm_we = 1'b1; gm_addr = a[10:0]; gm_data = d;
      @(negedge clk); gm_we = 1'b0;
   endtask

   task automatic wr_ct(input int a, input logic [11:0] d);
      @(negedge clk); ct_we = 1'b1; ct_addr = a[3:0]; ct_data = d;
      @(negedge clk); ct_we = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); px_valid = 1'b0;
      end
   endtask

   // drive one pixel and read its result three cycles later
   task automatic probe(input int x, input int y, input logic [11:0] exp, input string tag);
      @(negedge clk); px_valid = 1'b1; px_x = x[7:0]; px_y = y[6:0];
      @(negedge clk); px_valid = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check_eq({tag, " valid"}, {31'd0, pix_valid}, 32'd1);
      check_eq(tag, {20'd0, pix_color}, {20'd0, exp});
   endtask

   task automatic t_reset;
      cur_req = "R1";
      rst = 1'b1;
      idle(3);
      check_eq("R1 valid", {31'd0, pix_valid}, 32'd0);
      check_eq("R1 color", {20'd0, pix_color}, 32'd0);
      @(negedge clk); rst = 1'b0;
      mon_on = 1'b1;
   endtask

   task automatic t_load;
      cur_req = "R7";
      for (int i = 0; i < 16; i++) wr_ct(i, 12'h123 * i[11:0] + 12'h004);
      for (int i = 0; i < 512; i++) wr_cm(i, {i[7:0] * 8'd7, i[7:0] * 8'd13 + 8'd3});
      for (int g = 0; g < 256; g++)
         for (int r = 0; r < 8; r++)
            wr_gm(g * 8 + r, (g[7:0] * 8'd29 + r[7:0] * 8'd71 + 8'd17) ^ {1'b0, g[7:1]});
   endtask

   // full lines back to back
   task automatic t_scan(input int y0, input int step, input string tag);
      cur_req = tag;
      for (int y = y0; y < 128; y += step) begin
         for (int x = 0; x < 256; x++) begin
            @(negedge clk); px_valid = 1'b1; px_x = x[7:0]; px_y = y[6:0];
         end
      end
      idle(5);
      check_eq({tag, " drained"}, q_exp.size(), 32'd0);
   endtask

   task automatic t_bit_order;
      cur_req = "R4";
      // cell (col 3,row 2)=67: only leftmost bit set; cell 68: only rightmost
      wr_cm(67, {8'hF0, 8'h9C});
      wr_cm(68, {8'hF1, 8'h9C});
      for (int r = 0; r < 8; r++) begin
         wr_gm(8'hF0 * 8 + r, 8'h80);
         wr_gm(8'hF1 * 8 + r, 8'h01);
      end
      probe(24, 21, m_ct[9],  "R4 left bit fg");
      probe(25, 21, m_ct[12], "R4 second bit bg");
      probe(31, 21, m_ct[12], "R4 right bit bg");
      probe(39, 16, m_ct[9],  "R4 rightmost set fg");
      probe(32, 23, m_ct[12], "R4 leftmost clear bg");
   endtask

   task automatic t_attr;
      cur_req = "R5";
      // same glyph, swapped nibbles
      wr_cm(69, {8'hF0, 8'hC9});
      probe(40, 19, m_ct[12], "R5 fg nibble");
      probe(41, 19, m_ct[9],  "R5 bg nibble");
   endtask

   task automatic t_corners;
      cur_req = "R3";
      wr_cm(511, {8'hF0, 8'h5A});
      wr_cm(0,   {8'hF1, 8'h3E});
      wr_cm(32,  {8'hF1, 8'hE3});
      probe(248, 127, m_ct[5],  "R3 last cell fg");
      probe(255, 120, m_ct[10], "R3 last cell bg");
      probe(7, 0, m_ct[3],      "R3 first cell fg");
      probe(7, 8, m_ct[14],     "R3 second cell row fg");
   endtask

   task automatic t_rewrite;
      cur_req = "R7";
      wr_ct(9, 12'hABC);
      probe(24, 21, 12'hABC, "R7 color rewrite");
      wr_cm(67, {8'hF1, 8'h9C});
      probe(31, 21, 12'hABC, "R7 char rewrite");
      wr_gm(8'hF1 * 8 + 5, 8'h00);
      probe(31, 21, m_ct[12], "R7 glyph rewrite");
   endtask

   task automatic t_hold;
      cur_req = "R6";
      probe(248, 127, m_ct[5], "R6 setup");
      idle(4);
      check_eq("R6 held valid", {31'd0, pix_valid}, 32'd0);
      check_eq("R6 held color", {20'd0, pix_color}, {20'd0, m_ct[5]});
      for (int i = 0; i < 40; i++) begin
         @(negedge clk); px_valid = 1'b1; px_x = 8'(i * 37); px_y = 7'(i * 11);
         idle(i % 3);
      end
      idle(5);
   endtask

   task automatic t_mid_reset;
      cur_req = "R1";
      for (int i = 0; i < 3; i++) begin
         @(negedge clk); px_valid = 1'b1; px_x = 8'(i * 9); px_y = 7'(i * 5);
      end
      @(negedge clk); px_valid = 1'b0; rst = 1'b1;
      @(negedge clk);
      check_eq("R1 flush valid", {31'd0, pix_valid}, 32'd0);
      check_eq("R1 flush color", {20'd0, pix_color}, 32'd0);
      @(negedge clk); rst = 1'b0;
      idle(4);
      check_eq("R1 no late result", {31'd0, pix_valid}, 32'd0);
   endtask

   initial begin
      t_reset();
      t_load();
      t_scan(0, 9, "R8");
      t_bit_order();
      t_attr();
      t_corners();
      t_rewrite();
      t_scan(3, 10, "R3");
      t_hold();
      t_mid_reset();
      t_scan(5, 40, "R2");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 190000);
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule